// File: doc/BRIEF.md
# Scanline-Driven Interrupt Down-Counter

This block raises an interrupt request to the CPU once a programmed number of rendered scanlines have gone by. The CPU programs it through byte writes: one decoded address loads the 8-bit down-counter directly, another loads the 8-bit reload value, and two more turn counting on or off. The display side supplies a one-cycle pulse per scanline, the number of the current line, and the background and sprite display enables.

A scanline counts only if four conditions hold: it is a visible line (0 to 239), background or sprite display is on, counting is enabled, and no CPU write to the counter lands in the same cycle. On a counted line the counter is tested before it is decremented. If it was already zero, it takes the reload value and the interrupt request is set. If it was not zero, it decrements by one. The request is a level. It stays high until the CPU acknowledges it on a dedicated input or writes the disable address.

Top module: `scanline_irq_counter`

## Requirements
- R1: Reset clears the counter, the reload value, the enable and `irq`. With counting enabled after reset and nothing else written, the first qualifying scanline sets `irq`.
- R2: A write is decoded from `wr_addr & 16'hE001` only. Mirrored addresses reach the same function, e.g. 16'hDFFE loads the counter and 16'hFFFF enables counting. A masked address that matches no function is ignored.
- R3: A write with masked address 16'hC000 loads `wr_data` into the counter. A write with masked address 16'hC001 loads `wr_data` into the reload value.
- R4: A write to masked 16'hE001 enables counting. A write to masked 16'hE000 disables counting and clears `irq`. While counting is disabled, scanline pulses change nothing.
- R5: Only pulses with `line_num` from 0 to 239 count. Lines 240 and above are ignored.
- R6: A pulse counts only when `bg_on` or `spr_on` is high.
- R7: On a qualifying pulse a counter value of N is decremented when N is nonzero. When N is zero, the counter is reloaded from the reload value and `irq` is set. A counter written with N therefore sets `irq` on the (N+1)th qualifying line, and each later request follows (reload+1) lines.
- R8: `irq` goes high in the cycle after the clock edge that samples the firing pulse. It stays high until `irq_ack` or a disable write. A clear in the same cycle as a new firing wins, and `irq` reads 0.
- R9: When a counter write and a scanline pulse arrive in the same cycle, the write sets the counter. That pulse neither decrements the counter nor sets `irq`.
- R10: Address and data with `wr_en` low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| line_pulse | input | 1 | One-cycle pulse per scanline |
| line_num | input | 9 | Number of the current scanline |
| bg_on | input | 1 | Background display enabled |
| spr_on | input | 1 | Sprite display enabled |
| irq_ack | input | 1 | Clears the pending request |
| irq | output | 1 | Interrupt request level |

## Verification
Each input is sampled at a rising edge, and its effect on `irq` is visible right after that same edge: one register lies between a write, pulse or acknowledge and the output. The counter and reload value are not outputs, so each counter change is checked indirectly: the bench counts how many qualifying lines pass before `irq` rises. The driver applies one cycle of stimulus just after a rising edge. It enqueues the value a reference model predicts, tagged with the cycle in which it is due. The monitor compares it at the falling edge after the next rising edge, so every comparison falls exactly one register stage after its stimulus.

// File: rtl/scirq_pkg.sv
package scirq_pkg;

    // One-hot result of decoding a CPU write
    typedef struct packed {
        logic ld_cnt;
        logic ld_rel;
        logic en_clr;
        logic en_set;
    } scirq_wr_t;

endpackage

// File: rtl/scirq_decode.sv
module scirq_decode
    import scirq_pkg::*;
#(
    parameter int          ADDR_W = 16,
    parameter logic [15:0] MASK   = 16'hE001,
    parameter logic [15:0] A_CNT  = 16'hC000,
    parameter logic [15:0] A_REL  = 16'hC001,
    parameter logic [15:0] A_OFF  = 16'hE000,
    parameter logic [15:0] A_ON   = 16'hE001
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output scirq_wr_t         op
);

    localparam logic [ADDR_W-1:0] M = ADDR_W'(MASK);

    logic [ADDR_W-1:0] masked;

    always_comb begin
        masked    = wr_addr & M;
        op        = '0;
        op.ld_cnt = wr_en && (masked == ADDR_W'(A_CNT));
        op.ld_rel = wr_en && (masked == ADDR_W'(A_REL));
        op.en_clr = wr_en && (masked == ADDR_W'(A_OFF));
        op.en_set = wr_en && (masked == ADDR_W'(A_ON));
    end

endmodule

// File: rtl/scirq_count.sv
module scirq_count
    import scirq_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int LINE_W    = 9,
    parameter int LAST_LINE = 239
) (
    input  logic              clk,
    input  logic              rst_n,
    input  scirq_wr_t         op,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              line_pulse,
    input  logic [LINE_W-1:0] line_num,
    input  logic              bg_on,
    input  logic              spr_on,
    output logic              fire
);

    localparam logic [LINE_W-1:0] LAST = LINE_W'(LAST_LINE);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rel;
        logic             en;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    tick;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        tick = line_pulse && (line_num <= LAST) && (bg_on || spr_on) && st_q.en;

        // CPU write to the counter wins over a scanline in the same cycle
        if (op.ld_cnt) begin
            st_d.cnt = wr_data;
        end else if (tick) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = st_q.rel;
                fire     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end

        if (op.ld_rel) st_d.rel = wr_data;

        if (op.en_clr)      st_d.en = 1'b0;
        else if (op.en_set) st_d.en = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/scirq_flag.sv
module scirq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic clr,
    output logic irq
);

    logic irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (clr)       irq_d = 1'b0;
        else if (fire) irq_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq = irq_q;

endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
    import scirq_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int CNT_W     = 8,
    parameter int LINE_W    = 9,
    parameter int LAST_LINE = 239
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              line_pulse,
    input  logic [LINE_W-1:0] line_num,
    input  logic              bg_on,
    input  logic              spr_on,
    input  logic              irq_ack,
    output logic              irq
);

    scirq_wr_t op;
    logic      fire;

    scirq_decode #(
        .ADDR_W (ADDR_W)
    ) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .op      (op)
    );

    scirq_count #(
        .CNT_W     (CNT_W),
        .LINE_W    (LINE_W),
        .LAST_LINE (LAST_LINE)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .wr_data    (wr_data),
        .line_pulse (line_pulse),
        .line_num   (line_num),
        .bg_on      (bg_on),
        .spr_on     (spr_on),
        .fire       (fire)
    );

    scirq_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (fire),
        .clr   (op.en_clr || irq_ack),
        .irq   (irq)
    );

endmodule

// File: rtl/scirq_chk.sv
module scirq_chk #(
    parameter int ADDR_W    = 16,
    parameter int LINE_W    = 9,
    parameter int LAST_LINE = 239
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              line_pulse,
    input logic [LINE_W-1:0] line_num,
    input logic              bg_on,
    input logic              spr_on,
    input logic              irq_ack,
    input logic              irq
);

    logic [ADDR_W-1:0] m;
    logic              w_off, w_cnt;

    always_comb begin
        m     = wr_addr & ADDR_W'(16'hE001);
        w_off = wr_en && (m == ADDR_W'(16'hE000));
        w_cnt = wr_en && (m == ADDR_W'(16'hC000));
    end

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !irq_ack && !w_off |=> irq);

    // R8
    irq_ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq);

    // R4
    irq_off_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_off |=> !irq);

    // R7
    irq_needs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_pulse |=> !$rose(irq));

    // R5
    irq_visible_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_num > LINE_W'(LAST_LINE) |=> !$rose(irq));

    // R6
    irq_render_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bg_on || spr_on) |=> !$rose(irq));

    // R9
    irq_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_cnt |=> !$rose(irq));

endmodule

bind scanline_irq_counter scirq_chk #(
    .ADDR_W    (ADDR_W),
    .LINE_W    (LINE_W),
    .LAST_LINE (LAST_LINE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .line_pulse (line_pulse),
    .line_num   (line_num),
    .bg_on      (bg_on),
    .spr_on     (spr_on),
    .irq_ack    (irq_ack),
    .irq        (irq)
);

// File: tb/scanline_irq_counter_tb.sv
module scanline_irq_counter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        line_pulse = 1'b0;
    logic [8:0]  line_num = '0;
    logic        bg_on = 1'b0;
    logic        spr_on = 1'b0;
    logic        irq_ack = 1'b0;
    logic        irq;

    always #2 clk = ~clk; // 250 MHz

    scanline_irq_counter u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .line_pulse (line_pulse),
        .line_num   (line_num),
        .bg_on      (bg_on),
        .spr_on     (spr_on),
        .irq_ack    (irq_ack),
        .irq        (irq)
    );

    typedef struct {
        logic  exp;
        int    due;
        string tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    n_run = 0;
    int    n_fail = 0;
    bit    finished = 0;

    // reference model state
    logic [7:0] m_cnt = '0, m_rel = '0;
    logic       m_en = 1'b0, m_irq = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            it = q.pop_front();
            n_run++;
            if (irq !== it.exp) begin
                n_fail++;
                $display("FAIL %s: irq=%b expected %b at cycle %0d", it.tag, irq, it.exp, cyc);
            end
        end
    end

    // driver: one cycle of stimulus, model update, expectation pushed
    task automatic step(input bit we, input logic [15:0] a, input logic [7:0] d,
                        input bit lp, input logic [8:0] ln, input bit bg, input bit sp,
                        input bit ack, input string tag);
        logic [15:0] ma;
        bit          tick, fire;
        item_t       it;
        @(posedge clk);
        #1;
        wr_en = we; wr_addr = a; wr_data = d;
        line_pulse = lp; line_num = ln; bg_on = bg; spr_on = sp; irq_ack = ack;
        ma   = a & 16'hE001;
        tick = lp && (ln <= 9'd239) && (bg || sp) && m_en;
        fire = 0;
        if (we && ma == 16'hC000) m_cnt = d;
        else if (tick) begin
            if (m_cnt == 8'd0) begin m_cnt = m_rel; fire = 1; end
            else m_cnt = m_cnt - 8'd1;
        end
        if (we && ma == 16'hC001) m_rel = d;
        if ((we && ma == 16'hE000) || ack) m_irq = 1'b0;
        else if (fire) m_irq = 1'b1;
        if (we && ma == 16'hE000) m_en = 1'b0;
        else if (we && ma == 16'hE001) m_en = 1'b1;
        it.exp = m_irq; it.due = cyc + 1; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
        step(1, a, d, 0, 9'd0, 0, 0, 0, tag);
    endtask

    task automatic line(input logic [8:0] ln, input bit bg, input bit sp, input string tag);
        step(0, 16'h0, 8'h0, 1, ln, bg, sp, 0, tag);
    endtask

    task automatic idle(input string tag);
        step(0, 16'h0, 8'h0, 0, 9'd0, 0, 0, 0, tag);
    endtask

    task automatic ack(input string tag);
        step(0, 16'h0, 8'h0, 0, 9'd0, 0, 0, 1, tag);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        n_run++;
        if (irq !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: irq=%b expected 0 after reset", irq);
        end

        // R1: disabled after reset, lines do nothing
        for (int i = 0; i < 3; i++) line(9'd10, 1, 1, "R1");
        // R4 enable; R1 counter is zero so the first line fires
        wr(16'hE001, 8'h00, "R4");
        line(9'd10, 1, 1, "R1");
        // R8 level held, then acknowledged
        for (int i = 0; i < 3; i++) idle("R8");
        ack("R8");

        // R3 / R7: counter 2, reload 3
        wr(16'hC001, 8'd3, "R3");
        wr(16'hC000, 8'd2, "R3");
        for (int i = 0; i < 3; i++) line(9'd20, 1, 1, "R7");
        ack("R8");
        for (int i = 0; i < 4; i++) line(9'd21, 1, 1, "R7");
        ack("R8");

        // R5: invisible lines ignored, line 239 counts
        line(9'd240, 1, 1, "R5");
        line(9'd300, 1, 1, "R5");
        for (int i = 0; i < 4; i++) line(9'd239, 1, 1, "R5");
        ack("R8");

        // R6: no rendering -> ignored, sprites alone count
        for (int i = 0; i < 5; i++) line(9'd5, 0, 0, "R6");
        for (int i = 0; i < 4; i++) line(9'd5, 0, 1, "R6");
        ack("R8");

        // R9: counter write and line in the same cycle
        step(1, 16'hC000, 8'd1, 1, 9'd5, 1, 1, 0, "R9");
        line(9'd6, 1, 1, "R9");
        line(9'd7, 1, 1, "R9");

        // R10: strobe low, disable address ignored while irq is high
        step(0, 16'hE000, 8'h00, 0, 9'd0, 0, 0, 0, "R10");
        idle("R10");

        // R4: disable clears irq and stops counting
        wr(16'hE000, 8'h00, "R4");
        for (int i = 0; i < 6; i++) line(9'd8, 1, 1, "R4");

        // R2: mirrored addresses, unmatched address ignored
        wr(16'hFFFF, 8'h00, "R2");
        wr(16'hDFFE, 8'd0, "R2");
        wr(16'hBFFF, 8'h55, "R2");
        line(9'd9, 1, 1, "R2");
        idle("R2");

        // R8: clear beats a firing in the same cycle
        wr(16'hC000, 8'd0, "R8");
        step(0, 16'h0, 8'h0, 1, 9'd11, 1, 1, 1, "R8");
        idle("R8");

        idle("R7");
        repeat (3) @(posedge clk);
        @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #20000;
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule